// File: doc/BRIEF.md
# Function Configuration Header Register File

This block holds the 64-byte standard configuration header of one peripheral function and serves reads and writes to it through a small register port. Each access gives a byte offset, a byte count of 1, 2 or 4, a write flag and, for writes, the data. One cycle after the access the block returns a response strobe. The strobe carries the read data, assembled little-endian, and at most one of three fault flags.

All fields reset to values fixed by parameters. These are the identifiers, the class code, the command and status words, the header type, the interrupt routing bytes, six base address windows and the expansion ROM base. Configuration software can size each base window by writing all ones and reading the result back. The block then returns a mask built from the window's parameterised power-of-two size. The low type bits of every window keep their reset value whatever is written. The expansion ROM base has its own sizing code. Read-only fields ignore writes without complaint. Writes to any other place raise a one-cycle fault flag and change nothing.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: After reset every header byte reads back its parameter value; the header layout is: vendor id at 0x00, device id at 0x02, command at 0x04, status at 0x06, revision at 0x08, class code bytes at 0x09..0x0B, cache line size at 0x0C, latency timer at 0x0D, base windows at 0x10 + 4*n, ROM base at 0x30, interrupt line at 0x3C, interrupt pin at 0x3D, minimum grant at 0x3E, maximum latency at 0x3F.
- R2: A read of size N at offset A returns byte A in bits 7:0 through byte A+N-1, with unused upper bits zero; any byte alignment is allowed.
- R3: An access whose size is not 1, 2 or 4 sets size_err, returns zero data and changes no state.
- R4: An access of legal size with offset + size greater than 64 sets range_err, returns zero data and changes no state; an access ending exactly at byte 63 is legal.
- R5: A 4-byte write of 0xFFFFFFFF to base window n loads it with the inverse of (size_n - 1) outside its type bits; a window of size 0 then reads back only its type bits.
- R6: The type bits of a window never change: the low 2 bits when bit 0 of the reset value is 1 (I/O), otherwise the low 4 bits; any other 4-byte write stores the data with those bits replaced by the old ones.
- R7: A 4-byte write of 0xFFFFFFFE to the ROM base makes it read 0xFFFFFFFF; any other 4-byte value is stored as written.
- R8: 1-byte writes to revision, the three class code bytes, interrupt pin, minimum grant and maximum latency raise no flag and leave those bytes unchanged.
- R9: 1-byte writes update the interrupt line, cache line size and latency timer.
- R10: A 2-byte write at 0x04 sets the command word; a 4-byte write at 0x04 sets the command word from bits 15:0 and leaves status unchanged.
- R11: Any other write of legal size and range sets illegal_wr for one response and changes no state.
- R12: rsp_vld is high exactly in the cycle after each cycle with acc_en high; the three fault flags are mutually exclusive and only high together with rsp_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Byte offset into the header |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data, little-endian from bit 0 |
| rsp_vld | output | 1 | Response strobe, one cycle after acc_en |
| rd_data | output | 32 | Read data (zero for writes and faults) |
| size_err | output | 1 | Access size was not 1, 2 or 4 |
| range_err | output | 1 | Access reached past byte 63 |
| illegal_wr | output | 1 | Write to a field that accepts none |

## Verification
The bench builds the block with a mix of window types. Window 0 is a 4 KiB memory window, window 1 a 256-byte I/O window with type bit 0 set, window 2 has size zero, window 3 is a 1 MiB memory window with reset type 0x8, and window 5 is a 16-byte memory window. This puts both type masks, the zero-size case and the smallest and a large power-of-two size within reach of sizing and ordinary writes. The identifier, class and interrupt parameters have distinct byte values, so any byte-lane or endianness slip shows up in misaligned and boundary reads at 0x01, 0x08 and 0x3E.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int HDR_BYTES = 64;
    localparam int NUM_BARS  = 6;

    localparam logic [7:0] OFS_CMD   = 8'h04;
    localparam logic [7:0] OFS_REV   = 8'h08;
    localparam logic [7:0] OFS_PIF   = 8'h09;
    localparam logic [7:0] OFS_SUB   = 8'h0A;
    localparam logic [7:0] OFS_CLASS = 8'h0B;
    localparam logic [7:0] OFS_CLS   = 8'h0C;
    localparam logic [7:0] OFS_LAT   = 8'h0D;
    localparam logic [7:0] OFS_BAR0  = 8'h10;
    localparam logic [7:0] OFS_BARN  = 8'h24;
    localparam logic [7:0] OFS_ROM   = 8'h30;
    localparam logic [7:0] OFS_ILINE = 8'h3C;
    localparam logic [7:0] OFS_IPIN  = 8'h3D;
    localparam logic [7:0] OFS_MGNT  = 8'h3E;
    localparam logic [7:0] OFS_MLAT  = 8'h3F;

    localparam logic [31:0] ROM_SIZE_KEY = 32'hFFFF_FFFE;

    typedef enum logic [3:0] {
        WA_NONE,
        WA_IGNORE,
        WA_ILLEGAL,
        WA_ILINE,
        WA_CLS,
        WA_LAT,
        WA_CMD,
        WA_BAR,
        WA_ROM
    } wr_act_e;

    typedef struct packed {
        wr_act_e    act;
        logic [2:0] bar_idx;
        logic       size_bad;
        logic       range_bad;
    } acc_class_t;

    // Next value of a base window after a 4-byte write.
    function automatic logic [31:0] bar_next(input logic [31:0] old_v,
                                             input logic [31:0] wdata,
                                             input logic [31:0] win_size);
        logic [31:0] keep;
        logic [31:0] nv;
        keep = old_v[0] ? 32'h0000_0003 : 32'h0000_000F;
        nv   = (wdata == 32'hFFFF_FFFF) ? ~(win_size - 32'd1) : wdata;
        return (nv & ~keep) | (old_v & keep);
    endfunction

endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
    import cfg_hdr_pkg::*;
(
    input  logic [7:0]  off,
    input  logic [2:0]  size,
    input  logic        wr,
    output acc_class_t  cls
);
    logic [8:0] end_pos;

    always_comb begin
        cls          = '0;
        cls.act      = WA_NONE;
        end_pos      = {1'b0, off} + {6'd0, size};
        cls.size_bad = !(size == 3'd1 || size == 3'd2 || size == 3'd4);
        cls.range_bad = !cls.size_bad && (end_pos > 9'(HDR_BYTES));
        if (wr && !cls.size_bad && !cls.range_bad) begin
            cls.act = WA_ILLEGAL;
            case (size)
                3'd1: begin
                    if (off == OFS_ILINE) cls.act = WA_ILINE;
                    else if (off == OFS_CLS) cls.act = WA_CLS;
                    else if (off == OFS_LAT) cls.act = WA_LAT;
                    else if (off == OFS_REV || off == OFS_PIF || off == OFS_SUB ||
                             off == OFS_CLASS || off == OFS_IPIN ||
                             off == OFS_MGNT || off == OFS_MLAT)
                        cls.act = WA_IGNORE;
                end
                3'd2: begin
                    if (off == OFS_CMD) cls.act = WA_CMD;
                end
                default: begin
                    if (off == OFS_CMD) cls.act = WA_CMD;
                    else if (off == OFS_ROM) cls.act = WA_ROM;
                    else if (off >= OFS_BAR0 && off <= OFS_BARN && off[1:0] == 2'b00) begin
                        cls.act     = WA_BAR;
                        cls.bar_idx = 3'((off - OFS_BAR0) >> 2);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] RST_VAL  = 32'h0,
    parameter logic [31:0] WIN_SIZE = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] value
);
    always_ff @(posedge clk) begin
        if (rst)     value <= RST_VAL;
        else if (we) value <= bar_next(value, wdata, WIN_SIZE);
    end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_hdr_pkg::*;
(
    input  logic [HDR_BYTES-1:0][7:0] image,
    input  logic [7:0]                off,
    input  logic [2:0]                size,
    output logic [31:0]               data
);
    logic [8:0] pos;

    always_comb begin
        data = '0;
        pos  = '0;
        for (int i = 0; i < 4; i++) begin
            pos = {1'b0, off} + 9'(i);
            if (3'(i) < size && pos < 9'(HDR_BYTES))
                data[8*i +: 8] = image[pos[5:0]];
        end
    end
endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1AF4,
    parameter logic [15:0] DEVICE_ID   = 16'h0001,
    parameter logic [7:0]  REVISION    = 8'h00,
    parameter logic [23:0] CLASS_CODE  = 24'h020000,
    parameter logic [15:0] CMD_RST     = 16'h0000,
    parameter logic [15:0] STATUS_VAL  = 16'h0000,
    parameter logic [7:0]  CLS_RST     = 8'h00,
    parameter logic [7:0]  LAT_RST     = 8'h00,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter logic [7:0]  BIST_VAL    = 8'h00,
    parameter logic [31:0] CIS_PTR     = 32'h0,
    parameter logic [15:0] SUB_VENDOR  = 16'h0000,
    parameter logic [15:0] SUB_ID      = 16'h0000,
    parameter logic [31:0] ROM_RST     = 32'h0,
    parameter logic [7:0]  ILINE_RST   = 8'h00,
    parameter logic [7:0]  IRQ_PIN     = 8'h01,
    parameter logic [7:0]  MIN_GNT     = 8'h00,
    parameter logic [7:0]  MAX_LAT     = 8'h00,
    parameter logic [NUM_BARS-1:0][31:0] BAR_RST  = '0,
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = {32'h0, 32'h0, 32'h0,
                                                    32'h0, 32'h0, 32'h0000_1000}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic [7:0]  acc_off,
    input  logic [2:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output logic        rsp_vld,
    output logic [31:0] rd_data,
    output logic        size_err,
    output logic        range_err,
    output logic        illegal_wr
);
    acc_class_t                   cls;
    logic [15:0]                  cmd_q;
    logic [7:0]                   cls_q, lat_q, iline_q;
    logic [31:0]                  rom_q;
    logic [NUM_BARS-1:0][31:0]    bar_val;
    logic [HDR_BYTES-1:0][7:0]    image;
    logic [31:0]                  rd_mux;
    logic                         wr_go;

    cfg_access_decode u_dec (
        .off  (acc_off),
        .size (acc_size),
        .wr   (acc_wr),
        .cls  (cls)
    );

    assign wr_go = acc_en && acc_wr;

    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
        cfg_bar_slot #(
            .RST_VAL  (BAR_RST[b]),
            .WIN_SIZE (BAR_SIZE[b])
        ) u_slot (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_go && cls.act == WA_BAR && cls.bar_idx == 3'(b)),
            .wdata (acc_wdata),
            .value (bar_val[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_RST;
            cls_q   <= CLS_RST;
            lat_q   <= LAT_RST;
            iline_q <= ILINE_RST;
            rom_q   <= ROM_RST;
        end else if (wr_go) begin
            case (cls.act)
                WA_ILINE: iline_q <= acc_wdata[7:0];
                WA_CLS:   cls_q   <= acc_wdata[7:0];
                WA_LAT:   lat_q   <= acc_wdata[7:0];
                WA_CMD:   cmd_q   <= acc_wdata[15:0];
                WA_ROM:   rom_q   <= (acc_wdata == ROM_SIZE_KEY) ? 32'hFFFF_FFFF : acc_wdata;
                default:  ;
            endcase
        end
    end

    // Byte image of the header, little-endian per field.
    always_comb begin
        image          = '0;
        image[8'h00]   = VENDOR_ID[7:0];
        image[8'h01]   = VENDOR_ID[15:8];
        image[8'h02]   = DEVICE_ID[7:0];
        image[8'h03]   = DEVICE_ID[15:8];
        image[8'h04]   = cmd_q[7:0];
        image[8'h05]   = cmd_q[15:8];
        image[8'h06]   = STATUS_VAL[7:0];
        image[8'h07]   = STATUS_VAL[15:8];
        image[OFS_REV] = REVISION;
        image[OFS_PIF] = CLASS_CODE[7:0];
        image[OFS_SUB] = CLASS_CODE[15:8];
        image[OFS_CLASS] = CLASS_CODE[23:16];
        image[OFS_CLS] = cls_q;
        image[OFS_LAT] = lat_q;
        image[8'h0E]   = HEADER_TYPE;
        image[8'h0F]   = BIST_VAL;
        for (int b = 0; b < NUM_BARS; b++)
            for (int k = 0; k < 4; k++)
                image[16 + 4*b + k] = bar_val[b][8*k +: 8];
        for (int k = 0; k < 4; k++) begin
            image[8'h28 + k] = CIS_PTR[8*k +: 8];
            image[OFS_ROM + 8'(k)] = rom_q[8*k +: 8];
        end
        image[8'h2C]    = SUB_VENDOR[7:0];
        image[8'h2D]    = SUB_VENDOR[15:8];
        image[8'h2E]    = SUB_ID[7:0];
        image[8'h2F]    = SUB_ID[15:8];
        image[OFS_ILINE] = iline_q;
        image[OFS_IPIN]  = IRQ_PIN;
        image[OFS_MGNT]  = MIN_GNT;
        image[OFS_MLAT]  = MAX_LAT;
    end

    cfg_read_mux u_rmux (
        .image (image),
        .off   (acc_off),
        .size  (acc_size),
        .data  (rd_mux)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld    <= 1'b0;
            rd_data    <= '0;
            size_err   <= 1'b0;
            range_err  <= 1'b0;
            illegal_wr <= 1'b0;
        end else begin
            rsp_vld    <= acc_en;
            size_err   <= acc_en && cls.size_bad;
            range_err  <= acc_en && cls.range_bad;
            illegal_wr <= acc_en && cls.act == WA_ILLEGAL;
            rd_data    <= (acc_en && !acc_wr && !cls.size_bad && !cls.range_bad)
                          ? rd_mux : 32'h0;
        end
    end
endmodule

// File: rtl/cfg_hdr_regfile_chk.sv
module cfg_hdr_regfile_chk
    import cfg_hdr_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      acc_en,
    input logic [7:0]                acc_off,
    input logic [2:0]                acc_size,
    input logic                      rsp_vld,
    input logic [31:0]               rd_data,
    input logic                      size_err,
    input logic                      range_err,
    input logic                      illegal_wr,
    input logic [NUM_BARS-1:0][31:0] bar_val
);
    logic legal_sz;
    assign legal_sz = (acc_size == 3'd1 || acc_size == 3'd2 || acc_size == 3'd4);

    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> rsp_vld);

    // R12
    no_rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> !rsp_vld);

    // R12
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({size_err, range_err, illegal_wr}));

    // R12
    flag_needs_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (size_err || range_err || illegal_wr) |-> rsp_vld);

    // R3
    bad_size_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !legal_sz) |=> (size_err && rd_data == 32'h0));

    // R4
    past_end_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && legal_sz && ({1'b0, acc_off} + {6'd0, acc_size} > 9'(HDR_BYTES)))
        |=> (range_err && rd_data == 32'h0));

    // R6
    for (genvar b = 0; b < NUM_BARS; b++) begin : g_type
        bar_type_hold_chk: assert property (@(posedge clk) disable iff (rst)
            $stable(bar_val[b][1:0]));
    end
endmodule

bind cfg_hdr_regfile cfg_hdr_regfile_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_en     (acc_en),
    .acc_off    (acc_off),
    .acc_size   (acc_size),
    .rsp_vld    (rsp_vld),
    .rd_data    (rd_data),
    .size_err   (size_err),
    .range_err  (range_err),
    .illegal_wr (illegal_wr),
    .bar_val    (bar_val)
);

// File: tb/cfg_hdr_regfile_tb.sv
module cfg_hdr_regfile_tb;

    typedef struct {
        logic [31:0] rd;
        logic [2:0]  flg;
        int          cyc;
        string       req;
    } exp_t;

    localparam logic [2:0] F_OK = 3'b000, F_SZ = 3'b100, F_RG = 3'b010, F_IL = 3'b001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [7:0]  acc_off = '0;
    logic [2:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        rsp_vld, size_err, range_err, illegal_wr;
    logic [31:0] rd_data;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 0;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cfg_hdr_regfile #(
        .VENDOR_ID  (16'hABCD),
        .DEVICE_ID  (16'h1234),
        .REVISION   (8'h05),
        .CLASS_CODE (24'h0C0310),
        .STATUS_VAL (16'h0290),
        .SUB_VENDOR (16'h5A5A),
        .SUB_ID     (16'hC3C3),
        .ILINE_RST  (8'h0B),
        .IRQ_PIN    (8'h01),
        .MIN_GNT    (8'h22),
        .MAX_LAT    (8'h33),
        .BAR_RST    ({32'h0, 32'h0, 32'h8, 32'h0, 32'h1, 32'h0}),
        .BAR_SIZE   ({32'h10, 32'h0, 32'h0010_0000, 32'h0, 32'h100, 32'h1000})
    ) u_dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rsp_vld(rsp_vld), .rd_data(rd_data), .size_err(size_err),
        .range_err(range_err), .illegal_wr(illegal_wr)
    );

    task automatic acc(input logic wr, input logic [7:0] off, input logic [2:0] sz,
                       input logic [31:0] wd, input logic [31:0] exp_rd,
                       input logic [2:0] exp_flg, input string req);
        exp_t e;
        @(posedge clk); #1;
        acc_en = 1'b1; acc_wr = wr; acc_off = off; acc_size = sz; acc_wdata = wd;
        e.rd = exp_rd; e.flg = exp_flg; e.cyc = cyc + 1; e.req = req;
        q.push_back(e);
    endtask

    task automatic rd(input logic [7:0] off, input logic [2:0] sz,
                      input logic [31:0] exp_rd, input string req);
        acc(1'b0, off, sz, 32'h0, exp_rd, F_OK, req);
    endtask

    task automatic wr(input logic [7:0] off, input logic [2:0] sz,
                      input logic [31:0] wd, input logic [2:0] exp_flg, input string req);
        acc(1'b1, off, sz, wd, 32'h0, exp_flg, req);
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        acc_en = 1'b0; acc_wr = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    // Monitor: pops one expected item per response.
    always @(negedge clk) begin
        if (!rst && rsp_vld) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R12 unexpected response: actual rd=%h expected none", rd_data);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rd_data !== e.rd || {size_err, range_err, illegal_wr} !== e.flg || cyc != e.cyc) begin
                    fails++;
                    $display("FAIL %s: actual rd=%h flags=%b cyc=%0d expected rd=%h flags=%b cyc=%0d",
                             e.req, rd_data, {size_err, range_err, illegal_wr}, cyc,
                             e.rd, e.flg, e.cyc);
                end
            end
        end
    end

    task automatic quiet_check(input string req);
        @(negedge clk);
        checks++;
        if (rsp_vld !== 1'b0 || {size_err, range_err, illegal_wr} !== 3'b000 || rd_data !== 32'h0) begin
            fails++;
            $display("FAIL %s idle: actual vld=%b flags=%b rd=%h expected 0 000 0", req,
                     rsp_vld, {size_err, range_err, illegal_wr}, rd_data);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual run still active expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        quiet_check("R1 reset");

        // R1 / R2 reset contents and little-endian assembly
        rd(8'h00, 3'd4, 32'h1234ABCD, "R1 ids");
        rd(8'h01, 3'd2, 32'h000034AB, "R2 misaligned half");
        rd(8'h0B, 3'd1, 32'h0000000C, "R2 class byte");
        rd(8'h08, 3'd4, 32'h0C031005, "R1 rev/class");
        rd(8'h04, 3'd4, 32'h02900000, "R1 cmd/status");
        rd(8'h14, 3'd4, 32'h00000001, "R1 io window reset");
        rd(8'h2C, 3'd4, 32'hC3C35A5A, "R1 subsystem");
        rd(8'h3E, 3'd2, 32'h00003322, "R4 last legal half");

        // R3 bad sizes
        acc(1'b0, 8'h00, 3'd3, 32'h0, 32'h0, F_SZ, "R3 read size 3");
        wr(8'h3C, 3'd0, 32'hFF, F_SZ, "R3 write size 0");
        rd(8'h3C, 3'd1, 32'h0000000B, "R3 no change");

        // R4 range
        acc(1'b0, 8'h3E, 3'd4, 32'h0, 32'h0, F_RG, "R4 read past end");
        acc(1'b0, 8'h40, 3'd1, 32'h0, 32'h0, F_RG, "R4 read at 0x40");
        wr(8'h3D, 3'd4, 32'hFFFF_FFFF, F_RG, "R4 write past end");

        // R5 sizing
        wr(8'h10, 3'd4, 32'hFFFF_FFFF, F_OK, "R5 size w0");
        wr(8'h14, 3'd4, 32'hFFFF_FFFF, F_OK, "R5 size w1");
        wr(8'h18, 3'd4, 32'hFFFF_FFFF, F_OK, "R5 size w2");
        wr(8'h1C, 3'd4, 32'hFFFF_FFFF, F_OK, "R5 size w3");
        wr(8'h24, 3'd4, 32'hFFFF_FFFF, F_OK, "R5 size w5");
        rd(8'h10, 3'd4, 32'hFFFFF000, "R5 mem 4K mask");
        rd(8'h14, 3'd4, 32'hFFFFFF01, "R5 io 256 mask");
        rd(8'h18, 3'd4, 32'h00000000, "R5 zero size");
        rd(8'h1C, 3'd4, 32'hFFF00008, "R5 1M mask keeps type");
        rd(8'h24, 3'd4, 32'hFFFFFFF0, "R5 16B mask");

        // R6 ordinary window writes
        wr(8'h10, 3'd4, 32'hC000_00FF, F_OK, "R6 mem write");
        wr(8'h14, 3'd4, 32'h0000_E0F2, F_OK, "R6 io write");
        wr(8'h1C, 3'd4, 32'h8000_0007, F_OK, "R6 mem type write");
        rd(8'h10, 3'd4, 32'hC00000F0, "R6 mem low 4 kept");
        rd(8'h14, 3'd4, 32'h0000E0F1, "R6 io low 2 kept");
        rd(8'h1C, 3'd4, 32'h80000008, "R6 type 8 kept");

        // R7 ROM base
        wr(8'h30, 3'd4, 32'hFFFF_FFFE, F_OK, "R7 rom key");
        rd(8'h30, 3'd4, 32'hFFFFFFFF, "R7 rom sizing");
        wr(8'h30, 3'd4, 32'h1234_0001, F_OK, "R7 rom plain");
        rd(8'h30, 3'd4, 32'h12340001, "R7 rom stored");

        // R8 silently ignored bytes
        wr(8'h08, 3'd1, 32'hEE, F_OK, "R8 rev");
        wr(8'h09, 3'd1, 32'hEE, F_OK, "R8 class 0");
        wr(8'h0B, 3'd1, 32'hEE, F_OK, "R8 class 2");
        wr(8'h3D, 3'd1, 32'hEE, F_OK, "R8 pin");
        wr(8'h3E, 3'd1, 32'hEE, F_OK, "R8 gnt");
        wr(8'h3F, 3'd1, 32'hEE, F_OK, "R8 lat max");
        rd(8'h08, 3'd4, 32'h0C031005, "R8 class unchanged");
        rd(8'h3C, 3'd4, 32'h3322010B, "R8 tail unchanged");

        // R9 byte-writable fields
        wr(8'h3C, 3'd1, 32'hFFFF_FF5A, F_OK, "R9 iline");
        wr(8'h0C, 3'd1, 32'h10, F_OK, "R9 cls");
        wr(8'h0D, 3'd1, 32'h40, F_OK, "R9 lat");
        rd(8'h0C, 3'd4, 32'h00004010, "R9 cls/lat");
        rd(8'h3C, 3'd1, 32'h0000005A, "R9 iline readback");

        // R10 command
        wr(8'h04, 3'd2, 32'h0000_0147, F_OK, "R10 cmd16");
        rd(8'h04, 3'd4, 32'h02900147, "R10 cmd16 read");
        wr(8'h04, 3'd4, 32'hFFFF_0006, F_OK, "R10 cmd32");
        rd(8'h04, 3'd4, 32'h02900006, "R10 status kept");

        // R11 illegal writes
        wr(8'h00, 3'd4, 32'hDEAD_BEEF, F_IL, "R11 ids");
        wr(8'h06, 3'd2, 32'hFFFF, F_IL, "R11 status");
        wr(8'h10, 3'd1, 32'h55, F_IL, "R11 byte to window");
        wr(8'h12, 3'd4, 32'h5555_5555, F_IL, "R11 misaligned window");
        wr(8'h0C, 3'd2, 32'hFFFF, F_IL, "R11 half at cls");
        rd(8'h00, 3'd4, 32'h1234ABCD, "R11 ids unchanged");
        rd(8'h10, 3'd4, 32'hC00000F0, "R11 window unchanged");
        rd(8'h0C, 3'd2, 32'h00004010, "R11 cls unchanged");

        idle(3);
        quiet_check("R12 quiet after traffic");
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R12 missing responses: actual %0d pending expected 0", q.size());
        end
        finish_run();
    end

endmodule